// File: doc/BRIEF.md
# Data-Memory Pipeline Stage

This block is the memory step of an in-order processor pipeline. Micro-ops enter through a small input queue. Each one carries a load predicate, a store predicate, two branch predicates (early and late), a byte address, store data, a branch target and a tag. When the micro-op at the head of the queue loads or stores, the stage presents a single request to a direct-mapped data cache. The request carries a type bit, the address and the store data. The cache answers in the same cycle with a hit, which also returns the read data, or with a miss.

On a miss the stage does nothing in that cycle. The micro-op stays at the head of the queue and the same request is presented again. On a hit, or when the micro-op touches no memory, the micro-op leaves the queue and moves into the output register with a load-data field added. If its late-branch predicate is set, the branch target goes out on a redirect wire to fetch for exactly that one cycle. Accesses are 32 bits wide and span four adjacent bytes in little-endian order. The cache itself, including refill, lies outside this block.

Top module: `dmem_stage`

## Requirements
- R1: A cache request (`mreq_valid`=1) is presented only when the head micro-op has its load or store predicate set and the output register can accept a result. `mreq_store` is 1 for a store and 0 for a load. `mreq_addr` is the micro-op's byte address.
- R2: On a miss (`mreq_valid`=1, `mrsp_hit`=0) the micro-op is not dequeued and nothing moves downstream. In every later cycle in which a request is presented, it has the same address and type until a hit occurs.
- R3: The access covers bytes addr..addr+3, little-endian. On a store, bits [8k+7:8k] of `mreq_wdata` go to byte addr+k. On a load hit, `dn_ldata` bits [8k+7:8k] equal byte addr+k as returned on `mrsp_rdata` bits [8k+7:8k].
- R4: A micro-op with neither a load nor a store advances without issuing any request. A micro-op that does not load (a store, or one with no access) carries a load field of zero.
- R5: Load and store predicates are never both set on an offered micro-op.
- R6: Early and late branch predicates are never both set on an offered micro-op.
- R7: `redir_valid` pulses for exactly one cycle, with `redir_pc` equal to the branch target. This happens only in the cycle a micro-op whose late-branch predicate is set advances, and never in a cycle in which the cache reports a miss.
- R8: Results leave in the order the micro-ops were accepted. While `dn_valid`=1 and `dn_ready`=0, the output holds its value.
- R9: The input queue holds DEPTH micro-ops. With the downstream stalled and only non-memory micro-ops offered, exactly DEPTH+1 are accepted (DEPTH in the queue plus one in the output register), after which `up_ready` is 0.
- R10: During reset, `up_ready`=1 and `dn_valid`, `mreq_valid` and `redir_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Micro-op offered |
| up_ready | output | 1 | Input queue has room |
| up_ld | input | 1 | Load predicate |
| up_st | input | 1 | Store predicate |
| up_early_br | input | 1 | Branch already taken in register-read step |
| up_late_br | input | 1 | Redirect from this stage |
| up_addr | input | 32 | Byte address |
| up_sdata | input | 32 | Store data |
| up_target | input | 32 | Late-branch target |
| up_tag | input | 8 | Micro-op tag |
| mreq_valid | output | 1 | Cache request |
| mreq_store | output | 1 | 1 = store, 0 = load |
| mreq_addr | output | 32 | Request byte address |
| mreq_wdata | output | 32 | Store data, byte k at bits 8k+7:8k |
| mrsp_hit | input | 1 | Same-cycle hit answer |
| mrsp_rdata | input | 32 | Read data on hit, byte k at bits 8k+7:8k |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | 32 | Redirect target |
| dn_valid | output | 1 | Result valid |
| dn_ready | input | 1 | Downstream accepts |
| dn_ld | output | 1 | Forwarded load predicate |
| dn_st | output | 1 | Forwarded store predicate |
| dn_early_br | output | 1 | Forwarded early-branch predicate |
| dn_late_br | output | 1 | Forwarded late-branch predicate |
| dn_addr | output | 32 | Forwarded address |
| dn_sdata | output | 32 | Forwarded store data |
| dn_target | output | 32 | Forwarded target |
| dn_tag | output | 8 | Forwarded tag |
| dn_ldata | output | 32 | Appended load field |

## Verification
The hardest situation to reach is a late-branch load or store that misses repeatedly while the downstream is stalling at the same time. In that case the request has to drop out, come back unchanged, and the redirect must fire only on the eventual hit. The bench's cache responder therefore misses 0, 1 or 2 times per request, chosen by address bits [3:2], while the downstream ready signal is randomly withheld about a quarter of the time. A separate phase holds the downstream stalled with non-memory micro-ops to fill the queue to its exact capacity.

// File: rtl/dmem_stage_pkg.sv
package dmem_stage_pkg;
  localparam int unsigned XLEN  = 32;
  localparam int unsigned BYTES = XLEN / 8;
  localparam int unsigned TAG_W = 8;

  typedef struct packed {
    logic             ld;
    logic             st;
    logic             early_br;
    logic             late_br;
    logic [XLEN-1:0]  addr;
    logic [XLEN-1:0]  sdata;
    logic [XLEN-1:0]  target;
    logic [TAG_W-1:0] tag;
  } uop_t;

  typedef struct packed {
    uop_t            uop;
    logic [XLEN-1:0] ldata;
  } res_t;
endpackage

// File: rtl/dmem_uop_fifo.sv
module dmem_uop_fifo
  import dmem_stage_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push,
  input  uop_t push_data,
  output logic push_ready,
  input  logic pop,
  output logic head_valid,
  output uop_t head
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  uop_t             slot_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             do_push, do_pop;

  assign push_ready = (cnt_q != FULL);
  assign head_valid = (cnt_q != '0);
  assign head       = slot_q[rd_q];
  assign do_push    = push && push_ready;
  assign do_pop     = pop && head_valid;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (do_push) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop)      cnt_n = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wr_q] <= push_data;
  end
endmodule

// File: rtl/dmem_access_ctl.sv
module dmem_access_ctl
  import dmem_stage_pkg::*;
(
  input  logic            head_valid,
  input  uop_t            head,
  input  logic            out_space,
  input  logic            rsp_hit,
  input  logic [XLEN-1:0] rsp_rdata,
  output logic            req_valid,
  output logic            req_store,
  output logic [XLEN-1:0] req_addr,
  output logic [XLEN-1:0] req_wdata,
  output logic            advance,
  output logic            redir_valid,
  output logic [XLEN-1:0] redir_pc,
  output res_t            result
);
  logic            needs_mem;
  logic [XLEN-1:0] ldata_w;

  assign needs_mem = head.ld || head.st;
  assign req_valid = head_valid && needs_mem && out_space;
  assign req_store = head.st;
  assign req_addr  = head.addr;

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    assign req_wdata[8*k +: 8] = head.sdata[8*k +: 8];
    assign ldata_w[8*k +: 8]   = head.ld ? rsp_rdata[8*k +: 8] : 8'h00;
  end

  assign advance     = head_valid && out_space && (!needs_mem || rsp_hit);
  assign redir_valid = advance && head.late_br;
  assign redir_pc    = head.target;

  always_comb begin
    result.uop   = head;
    result.ldata = ldata_w;
  end
endmodule

// File: rtl/dmem_out_reg.sv
module dmem_out_reg
  import dmem_stage_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  res_t in_data,
  input  logic dn_ready,
  output logic out_space,
  output logic dn_valid,
  output res_t dn_data
);
  logic valid_q, valid_n, load_en;
  res_t data_q;

  assign out_space = !valid_q || dn_ready;
  assign load_en   = out_space && in_valid;

  always_comb begin
    valid_n = valid_q;
    if (out_space) valid_n = in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk) begin
    if (load_en) data_q <= in_data;
  end

  assign dn_valid = valid_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/dmem_stage.sv
module dmem_stage
  import dmem_stage_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic             up_ld,
  input  logic             up_st,
  input  logic             up_early_br,
  input  logic             up_late_br,
  input  logic [XLEN-1:0]  up_addr,
  input  logic [XLEN-1:0]  up_sdata,
  input  logic [XLEN-1:0]  up_target,
  input  logic [TAG_W-1:0] up_tag,
  output logic             mreq_valid,
  output logic             mreq_store,
  output logic [XLEN-1:0]  mreq_addr,
  output logic [XLEN-1:0]  mreq_wdata,
  input  logic             mrsp_hit,
  input  logic [XLEN-1:0]  mrsp_rdata,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_pc,
  output logic             dn_valid,
  input  logic             dn_ready,
  output logic             dn_ld,
  output logic             dn_st,
  output logic             dn_early_br,
  output logic             dn_late_br,
  output logic [XLEN-1:0]  dn_addr,
  output logic [XLEN-1:0]  dn_sdata,
  output logic [XLEN-1:0]  dn_target,
  output logic [TAG_W-1:0] dn_tag,
  output logic [XLEN-1:0]  dn_ldata
);
  uop_t in_uop, head;
  res_t result, dn_res;
  logic head_valid, advance, out_space;

  always_comb begin
    in_uop.ld       = up_ld;
    in_uop.st       = up_st;
    in_uop.early_br = up_early_br;
    in_uop.late_br  = up_late_br;
    in_uop.addr     = up_addr;
    in_uop.sdata    = up_sdata;
    in_uop.target   = up_target;
    in_uop.tag      = up_tag;
  end

  dmem_uop_fifo #(.DEPTH(DEPTH)) i_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .push       (up_valid),
    .push_data  (in_uop),
    .push_ready (up_ready),
    .pop        (advance),
    .head_valid (head_valid),
    .head       (head)
  );

  dmem_access_ctl i_ctl (
    .head_valid  (head_valid),
    .head        (head),
    .out_space   (out_space),
    .rsp_hit     (mrsp_hit),
    .rsp_rdata   (mrsp_rdata),
    .req_valid   (mreq_valid),
    .req_store   (mreq_store),
    .req_addr    (mreq_addr),
    .req_wdata   (mreq_wdata),
    .advance     (advance),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc),
    .result      (result)
  );

  dmem_out_reg i_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (advance),
    .in_data   (result),
    .dn_ready  (dn_ready),
    .out_space (out_space),
    .dn_valid  (dn_valid),
    .dn_data   (dn_res)
  );

  assign dn_ld       = dn_res.uop.ld;
  assign dn_st       = dn_res.uop.st;
  assign dn_early_br = dn_res.uop.early_br;
  assign dn_late_br  = dn_res.uop.late_br;
  assign dn_addr     = dn_res.uop.addr;
  assign dn_sdata    = dn_res.uop.sdata;
  assign dn_target   = dn_res.uop.target;
  assign dn_tag      = dn_res.uop.tag;
  assign dn_ldata    = dn_res.ldata;
endmodule

// File: rtl/dmem_stage_chk.sv
module dmem_stage_chk
  import dmem_stage_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             up_valid,
  input logic             up_ld,
  input logic             up_st,
  input logic             up_early_br,
  input logic             up_late_br,
  input logic             mreq_valid,
  input logic             mreq_store,
  input logic [XLEN-1:0]  mreq_addr,
  input logic             mrsp_hit,
  input logic             redir_valid,
  input logic             dn_valid,
  input logic             dn_ready,
  input logic [TAG_W-1:0] dn_tag,
  input logic [XLEN-1:0]  dn_ldata
);
  AST_LOAD_STORE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> !(up_ld && up_st)); // R5

  AST_BRANCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> !(up_early_br && up_late_br)); // R6

  AST_MISS_RETRY_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_valid && !mrsp_hit) |=> (!mreq_valid || ($stable(mreq_addr) && $stable(mreq_store)))); // R2

  AST_NO_REDIRECT_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !(mreq_valid && !mrsp_hit)); // R7

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_tag) && $stable(dn_ldata))); // R8
endmodule

bind dmem_stage dmem_stage_chk i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .up_valid    (up_valid),
  .up_ld       (up_ld),
  .up_st       (up_st),
  .up_early_br (up_early_br),
  .up_late_br  (up_late_br),
  .mreq_valid  (mreq_valid),
  .mreq_store  (mreq_store),
  .mreq_addr   (mreq_addr),
  .mrsp_hit    (mrsp_hit),
  .redir_valid (redir_valid),
  .dn_valid    (dn_valid),
  .dn_ready    (dn_ready),
  .dn_tag      (dn_tag),
  .dn_ldata    (dn_ldata)
);

// File: tb/test_dmem_stage.sv
`timescale 1ns/1ps
module test_dmem_stage;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, up_valid, up_ready, up_ld, up_st, up_early_br, up_late_br;
  logic [31:0] up_addr, up_sdata, up_target;
  logic [7:0]  up_tag;
  logic        mreq_valid, mreq_store, mrsp_hit;
  logic [31:0] mreq_addr, mreq_wdata, mrsp_rdata;
  logic        redir_valid;
  logic [31:0] redir_pc;
  logic        dn_valid, dn_ready, dn_ld, dn_st, dn_early_br, dn_late_br;
  logic [31:0] dn_addr, dn_sdata, dn_target, dn_ldata;
  logic [7:0]  dn_tag;

  dmem_stage #(.DEPTH(DEPTH)) i_dmem_stage (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_ld(up_ld), .up_st(up_st), .up_early_br(up_early_br), .up_late_br(up_late_br),
    .up_addr(up_addr), .up_sdata(up_sdata), .up_target(up_target), .up_tag(up_tag),
    .mreq_valid(mreq_valid), .mreq_store(mreq_store), .mreq_addr(mreq_addr),
    .mreq_wdata(mreq_wdata), .mrsp_hit(mrsp_hit), .mrsp_rdata(mrsp_rdata),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .dn_valid(dn_valid),
    .dn_ready(dn_ready), .dn_ld(dn_ld), .dn_st(dn_st), .dn_early_br(dn_early_br),
    .dn_late_br(dn_late_br), .dn_addr(dn_addr), .dn_sdata(dn_sdata),
    .dn_target(dn_target), .dn_tag(dn_tag), .dn_ldata(dn_ldata)
  );

  // Cache responder: each request misses 0..2 times, chosen by addr[3:2]
  logic [7:0]  mem_b  [256];
  logic [7:0]  shadow [256];
  int unsigned stall_cnt = 0;

  function automatic int unsigned miss_need(input logic [31:0] a);
    return int'(a[3:2]) % 3;
  endfunction

  always_comb begin
    mrsp_hit = mreq_valid && (stall_cnt >= miss_need(mreq_addr));
    for (int k = 0; k < 4; k++)
      mrsp_rdata[8*k +: 8] = mem_b[mreq_addr[7:0] + 8'(k)];
  end

  always @(posedge clk) begin
    if (mreq_valid && mrsp_hit) begin
      stall_cnt <= 0;
      if (mreq_store)
        for (int k = 0; k < 4; k++) mem_b[mreq_addr[7:0] + 8'(k)] <= mreq_wdata[8*k +: 8];
    end else if (mreq_valid) begin
      stall_cnt <= stall_cnt + 1;
    end
  end

  // Reference model state
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0]  exp_tag_q[$];
  logic [31:0] exp_ld_q[$];
  bit          exp_isld_q[$];
  logic [31:0] req_addr_q[$], req_wd_q[$], redir_q[$];
  bit          req_st_q[$];
  bit          have_cur = 0, fill_mode = 0, prev_miss = 0, prev_st = 0;
  logic [31:0] prev_addr = 0;
  int          left = 0, seq = 0, acc_cnt = 0;
  logic        c_ld, c_st, c_eb, c_lb;
  logic [31:0] c_addr, c_sdata, c_tgt;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic gen();
    int kind;
    kind = fill_mode ? 0 : int'($urandom % 3);
    c_ld   = (kind == 1);
    c_st   = (kind == 2);
    c_lb   = !fill_mode && ($urandom % 4 == 0);
    c_eb   = !c_lb && ($urandom % 5 == 0);
    c_addr = $urandom % 252;
    c_sdata = $urandom;
    c_tgt  = $urandom;
    have_cur = 1;
  endtask

  task automatic model_push();
    logic [31:0] w;
    w = 0;
    if (c_ld)
      for (int k = 0; k < 4; k++) w[8*k +: 8] = shadow[c_addr[7:0] + 8'(k)];
    if (c_st)
      for (int k = 0; k < 4; k++) shadow[c_addr[7:0] + 8'(k)] = c_sdata[8*k +: 8];
    if (c_ld || c_st) begin
      req_addr_q.push_back(c_addr);
      req_st_q.push_back(c_st);
      req_wd_q.push_back(c_sdata);
    end
    if (c_lb) redir_q.push_back(c_tgt);
    exp_tag_q.push_back(8'(seq));
    exp_ld_q.push_back(w);
    exp_isld_q.push_back(c_ld);
    seq++;
    acc_cnt++;
  endtask

  task automatic step(input bit rdy);
    @(negedge clk);
    if (!have_cur && left > 0) begin gen(); left--; end
    up_valid = have_cur;
    up_ld = c_ld; up_st = c_st; up_early_br = c_eb; up_late_br = c_lb;
    up_addr = c_addr; up_sdata = c_sdata; up_target = c_tgt; up_tag = 8'(seq);
    dn_ready = rdy;
    #1;
    if (prev_miss)
      chk(!mreq_valid || (mreq_addr == prev_addr && mreq_store == prev_st),
          "R2", "retry changed", mreq_addr, prev_addr);
    if (mreq_valid) begin
      if (req_addr_q.size() == 0) chk(0, "R1", "unexpected request", mreq_addr, 0);
      else begin
        chk(mreq_addr == req_addr_q[0], "R1", "request addr", mreq_addr, req_addr_q[0]);
        chk(mreq_store == req_st_q[0], "R1", "request type", 32'(mreq_store), 32'(req_st_q[0]));
        if (req_st_q[0]) chk(mreq_wdata == req_wd_q[0], "R3", "store data", mreq_wdata, req_wd_q[0]);
        if (mrsp_hit) begin
          void'(req_addr_q.pop_front()); void'(req_st_q.pop_front()); void'(req_wd_q.pop_front());
        end
      end
    end
    prev_miss = mreq_valid && !mrsp_hit;
    prev_addr = mreq_addr;
    prev_st   = mreq_store;
    if (redir_valid) begin
      chk(!(mreq_valid && !mrsp_hit), "R7", "redirect in miss cycle", 1, 0);
      if (redir_q.size() == 0) chk(0, "R7", "unexpected redirect", redir_pc, 0);
      else begin
        chk(redir_pc == redir_q[0], "R7", "redirect target", redir_pc, redir_q[0]);
        void'(redir_q.pop_front());
      end
    end
    if (dn_valid && dn_ready) begin
      if (exp_tag_q.size() == 0) chk(0, "R8", "unexpected result", 32'(dn_tag), 0);
      else begin
        chk(dn_tag == exp_tag_q[0], "R8", "result order tag", 32'(dn_tag), 32'(exp_tag_q[0]));
        if (exp_isld_q[0]) chk(dn_ldata == exp_ld_q[0], "R3", "load data", dn_ldata, exp_ld_q[0]);
        else chk(dn_ldata == exp_ld_q[0], "R4", "non-load field", dn_ldata, exp_ld_q[0]);
        void'(exp_tag_q.pop_front()); void'(exp_ld_q.pop_front()); void'(exp_isld_q.pop_front());
      end
    end
    if (up_valid && up_ready) begin
      model_push();
      have_cur = 0;
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem_b[i]  = 8'(i * 7 + 3);
      shadow[i] = 8'(i * 7 + 3);
    end
    rst_n = 0; up_valid = 0; dn_ready = 0;
    up_ld = 0; up_st = 0; up_early_br = 0; up_late_br = 0;
    up_addr = 0; up_sdata = 0; up_target = 0; up_tag = 0;
    c_ld = 0; c_st = 0; c_eb = 0; c_lb = 0; c_addr = 0; c_sdata = 0; c_tgt = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(up_ready == 1, "R10", "reset up_ready", 32'(up_ready), 1);
    chk(dn_valid == 0, "R10", "reset dn_valid", 32'(dn_valid), 0);
    chk(mreq_valid == 0, "R10", "reset mreq_valid", 32'(mreq_valid), 0);
    chk(redir_valid == 0, "R10", "reset redir_valid", 32'(redir_valid), 0);
    rst_n = 1;

    // Mixed traffic with random downstream back-pressure and cache misses
    left = 600;
    for (int cyc = 0; cyc < 40000 && (left > 0 || have_cur || exp_tag_q.size() > 0); cyc++)
      step($urandom % 4 != 0);

    // R9: capacity with downstream stalled, non-memory micro-ops only
    fill_mode = 1; acc_cnt = 0; left = 10;
    repeat (12) step(0);
    chk(acc_cnt == DEPTH + 1, "R9", "accepted while stalled", acc_cnt, DEPTH + 1);
    chk(up_ready == 0, "R9", "up_ready when full", 32'(up_ready), 0);
    for (int cyc = 0; cyc < 200 && (left > 0 || have_cur || exp_tag_q.size() > 0); cyc++)
      step(1);

    chk(exp_tag_q.size() == 0, "R8", "results outstanding", exp_tag_q.size(), 0);
    chk(req_addr_q.size() == 0, "R1", "requests outstanding", req_addr_q.size(), 0);
    chk(redir_q.size() == 0, "R7", "redirects outstanding", redir_q.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule